// File: doc/BRIEF.md
# NZP Condition-Code Execution Unit

This unit is the arithmetic and branch-decision part of a small 16-bit accumulator-style processor. Each cycle in which `valid_i` is high, it decodes the opcode in the upper four bits of `instr_i` and acts on it.

For add, bitwise AND and bitwise NOT, it computes the write-back value. For loads, the write-back value is the data presented on `load_data_i`. For load-effective-address, it forms an address from the incremented PC. For conditional branches, it decides whether the branch is taken and computes the target.

The register file and the memory sit outside the unit. The unit receives operand values, the incremented PC and any loaded word as plain inputs, and returns a registered result one clock later.

The unit keeps a three-bit condition register with exactly one bit set: positive, zero or negative. Every instruction that writes a general register refreshes this condition register from the written value. A branch compares its own three-bit mask against the condition register.

Top module: `nzp_exec_unit`

## Requirements
- R1: While `rst_n` is low, and after its release until the first valid instruction, the outputs are as follows: `flags_o` is 3'b010 (zero), `wr_en_o` and `br_taken_o` are 0, and `result_o` and `br_target_o` are 0.
- R2: For opcodes 4'b0001 (add) and 4'b0101 (AND), `instr_i[5]`=0 selects `src_b_i` as the second operand. `instr_i[5]`=1 selects `instr_i[4:0]` sign-extended from bit 4, so 5'h16 becomes 16'hFFF6. When the immediate is selected, `src_b_i` has no effect.
- R3: Add results wrap modulo 2^16, and no carry or overflow indication exists.
- R4: Opcode 4'b1001 writes the bitwise complement of `src_a_i`.
- R5: After a write-back, `flags_o` holds one of three values: 3'b010 if the result is zero, 3'b100 if the result is nonzero with bit 15 set, and 3'b001 otherwise. Exactly one bit of `flags_o` is set at all times.
- R6: The flag-setting instructions are add, AND, NOT, the loads (4'b0010, 4'b0110, 4'b1010) and load-effective-address (4'b1110). Each raises `wr_en_o` and updates the flags. Loads write `load_data_i`. Load-effective-address writes `pc_i` plus `instr_i[8:0]` sign-extended.
- R7: The remaining opcodes are 0000, 0011, 0100, 0111, 1000, 1011, 1100, 1101 and 1111. They leave `flags_o` unchanged and keep `wr_en_o` at 0.
- R8: Opcode 4'b0000 is taken exactly when `instr_i[11:9]` (bit 11 = N, bit 10 = Z, bit 9 = P) ANDed with the current flags is nonzero. The target is `pc_i` plus `instr_i[8:0]` sign-extended, modulo 2^16.
- R9: A branch mask of 3'b000 is never taken. Because of the reset value of the flags, a mask of 3'b111 right after reset is taken.
- R10: All outputs change on the clock edge that samples the instruction. While `valid_i` is 0, `wr_en_o` and `br_taken_o` are 0 and the flags hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Instruction present this cycle |
| instr_i | input | 16 | Instruction word, opcode in bits 15:12 |
| src_a_i | input | 16 | First source register value |
| src_b_i | input | 16 | Second source register value |
| pc_i | input | 16 | Incremented program counter |
| load_data_i | input | 16 | Word returned by a load |
| result_o | output | 16 | Registered write-back value |
| wr_en_o | output | 1 | Write-back strobe for the last instruction |
| flags_o | output | 3 | One-hot condition register {N,Z,P} |
| br_taken_o | output | 1 | Last instruction was a taken branch |
| br_target_o | output | 16 | Target of the last branch |

## Verification
On every cycle, the embedded properties check the following:
- the condition register is one-hot;
- zero and negative write-backs select the matching flag;
- non-writing opcodes and idle cycles keep the flags;
- an empty branch mask never branches;
- a mask that overlaps the flags always branches.

Several behaviours can only be shown by the bench's scenarios, because they require computed expected values. These are:
- the arithmetic values themselves, including the sign-extended immediate and modulo-2^16 wrap;
- load and address write-back;
- branch targets with negative offsets;
- the reset value.

// File: rtl/nzp_pkg.sv
package nzp_pkg;
    localparam int WORD_W = 16;
    localparam int OPC_W  = 4;
    localparam int IMM_W  = 5;
    localparam int OFF_W  = 9;
    localparam int FLAG_W = 3;

    localparam logic [FLAG_W-1:0] FLAG_P = 3'b001;
    localparam logic [FLAG_W-1:0] FLAG_Z = 3'b010;
    localparam logic [FLAG_W-1:0] FLAG_N = 3'b100;

    typedef enum logic [OPC_W-1:0] {
        OP_BR   = 4'h0, OP_ADD = 4'h1, OP_LD   = 4'h2, OP_ST  = 4'h3,
        OP_JSR  = 4'h4, OP_AND = 4'h5, OP_LDR  = 4'h6, OP_STR = 4'h7,
        OP_RTI  = 4'h8, OP_NOT = 4'h9, OP_LDI  = 4'hA, OP_STI = 4'hB,
        OP_JMP  = 4'hC, OP_RSV = 4'hD, OP_LEA  = 4'hE, OP_TRAP = 4'hF
    } opcode_e;

    typedef struct packed {
        logic [WORD_W-1:0] result;
        logic              wr_en;
        logic [FLAG_W-1:0] flags;
        logic              br_taken;
        logic [WORD_W-1:0] br_target;
    } unit_state_t;
endpackage

// File: rtl/nzp_sext.sv
module nzp_sext #(
    parameter int IN_W  = 5,
    parameter int OUT_W = 16
) (
    input  logic [IN_W-1:0]  field_i,
    output logic [OUT_W-1:0] value_o
);
    localparam int PAD_W = OUT_W - IN_W;

    generate
        if (PAD_W > 0) begin : g_pad
            assign value_o = {{PAD_W{field_i[IN_W-1]}}, field_i};
        end else begin : g_nopad
            assign value_o = field_i[OUT_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/nzp_alu_core.sv
module nzp_alu_core
    import nzp_pkg::*;
(
    input  opcode_e           opc_i,
    input  logic              use_imm_i,
    input  logic [WORD_W-1:0] a_i,
    input  logic [WORD_W-1:0] b_reg_i,
    input  logic [WORD_W-1:0] imm_ext_i,
    input  logic [WORD_W-1:0] pc_i,
    input  logic [WORD_W-1:0] off_ext_i,
    input  logic [WORD_W-1:0] load_data_i,
    output logic [WORD_W-1:0] result_o,
    output logic              writes_o
);
    logic [WORD_W-1:0] operand_b;

    always_comb begin
        operand_b = use_imm_i ? imm_ext_i : b_reg_i;
        result_o  = '0;
        writes_o  = 1'b0;
        unique case (opc_i)
            OP_ADD: begin
                result_o = a_i + operand_b;
                writes_o = 1'b1;
            end
            OP_AND: begin
                result_o = a_i & operand_b;
                writes_o = 1'b1;
            end
            OP_NOT: begin
                result_o = ~a_i;
                writes_o = 1'b1;
            end
            OP_LD, OP_LDR, OP_LDI: begin
                result_o = load_data_i;
                writes_o = 1'b1;
            end
            OP_LEA: begin
                result_o = pc_i + off_ext_i;
                writes_o = 1'b1;
            end
            default: begin
                result_o = '0;
                writes_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/nzp_flag_gen.sv
module nzp_flag_gen
    import nzp_pkg::*;
(
    input  logic [WORD_W-1:0] value_i,
    output logic [FLAG_W-1:0] flags_o
);
    always_comb begin
        if (value_i == '0) begin
            flags_o = FLAG_Z;
        end else if (value_i[WORD_W-1]) begin
            flags_o = FLAG_N;
        end else begin
            flags_o = FLAG_P;
        end
    end
endmodule

// File: rtl/nzp_branch_eval.sv
module nzp_branch_eval
    import nzp_pkg::*;
(
    input  logic [FLAG_W-1:0] mask_i,
    input  logic [FLAG_W-1:0] flags_i,
    input  logic [WORD_W-1:0] pc_i,
    input  logic [WORD_W-1:0] off_ext_i,
    output logic              hit_o,
    output logic [WORD_W-1:0] target_o
);
    always_comb begin
        hit_o    = |(mask_i & flags_i);
        target_o = pc_i + off_ext_i;
    end
endmodule

// File: rtl/nzp_exec_unit.sv
module nzp_exec_unit
    import nzp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        valid_i,
    input  logic [15:0] instr_i,
    input  logic [15:0] src_a_i,
    input  logic [15:0] src_b_i,
    input  logic [15:0] pc_i,
    input  logic [15:0] load_data_i,
    output logic [15:0] result_o,
    output logic        wr_en_o,
    output logic [2:0]  flags_o,
    output logic        br_taken_o,
    output logic [15:0] br_target_o
);
    localparam int MASK_HI = WORD_W - OPC_W - 1;
    localparam int MASK_LO = MASK_HI - FLAG_W + 1;

    unit_state_t st_d, st_q;

    opcode_e           opc;
    logic [FLAG_W-1:0] br_mask;
    logic [WORD_W-1:0] imm_ext, off_ext, alu_result, br_target;
    logic [FLAG_W-1:0] new_flags;
    logic              alu_writes, br_hit;
    logic              unused_fields;

    assign opc           = opcode_e'(instr_i[WORD_W-1 -: OPC_W]);
    assign br_mask       = instr_i[MASK_HI:MASK_LO];
    assign unused_fields = ^instr_i[8:6];

    nzp_sext #(.IN_W(IMM_W), .OUT_W(WORD_W)) i_imm_sext (
        .field_i (instr_i[IMM_W-1:0]),
        .value_o (imm_ext)
    );

    nzp_sext #(.IN_W(OFF_W), .OUT_W(WORD_W)) i_off_sext (
        .field_i (instr_i[OFF_W-1:0]),
        .value_o (off_ext)
    );

    nzp_alu_core i_alu (
        .opc_i       (opc),
        .use_imm_i   (instr_i[IMM_W]),
        .a_i         (src_a_i),
        .b_reg_i     (src_b_i),
        .imm_ext_i   (imm_ext),
        .pc_i        (pc_i),
        .off_ext_i   (off_ext),
        .load_data_i (load_data_i),
        .result_o    (alu_result),
        .writes_o    (alu_writes)
    );

    nzp_flag_gen i_flags (
        .value_i (alu_result),
        .flags_o (new_flags)
    );

    nzp_branch_eval i_branch (
        .mask_i    (br_mask),
        .flags_i   (st_q.flags),
        .pc_i      (pc_i),
        .off_ext_i (off_ext),
        .hit_o     (br_hit),
        .target_o  (br_target)
    );

    always_comb begin
        st_d          = st_q;
        st_d.wr_en    = 1'b0;
        st_d.br_taken = 1'b0;
        if (valid_i) begin
            if (alu_writes) begin
                st_d.result = alu_result;
                st_d.wr_en  = 1'b1;
                st_d.flags  = new_flags;
            end
            if (opc == OP_BR) begin
                st_d.br_taken  = br_hit;
                st_d.br_target = br_target;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.result    <= '0;
            st_q.wr_en     <= 1'b0;
            st_q.flags     <= FLAG_Z;
            st_q.br_taken  <= 1'b0;
            st_q.br_target <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_o    = st_q.result;
    assign wr_en_o     = st_q.wr_en;
    assign flags_o     = st_q.flags;
    assign br_taken_o  = st_q.br_taken;
    assign br_target_o = st_q.br_target;

    a_r5_flags_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(flags_o) == 1);

    a_r5_zero_result: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o && (result_o == 16'h0000) |-> flags_o == 3'b010);

    a_r5_negative_result: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o && result_o[15] |-> flags_o == 3'b100);

    a_r7_flags_kept: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && (instr_i[15:12] inside {4'h0, 4'h3, 4'h4, 4'h7, 4'h8,
                                           4'hB, 4'hC, 4'hD, 4'hF})
        |=> $stable(flags_o) && !wr_en_o);

    a_r8_overlap_taken: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && (instr_i[15:12] == 4'h0) && ((instr_i[11:9] & flags_o) != 3'b000)
        |=> br_taken_o);

    a_r9_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && (instr_i[15:12] == 4'h0) && (instr_i[11:9] == 3'b000)
        |=> !br_taken_o);

    a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !wr_en_o && !br_taken_o && $stable(flags_o));
endmodule

// File: tb/test_nzp_exec_unit.sv
module test_nzp_exec_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [15:0] instr_i = '0, src_a_i = '0, src_b_i = '0, pc_i = '0, load_data_i = '0;
    logic [15:0] result_o, br_target_o;
    logic        wr_en_o, br_taken_o;
    logic [2:0]  flags_o;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    nzp_exec_unit i_nzp_exec_unit (
        .clk, .rst_n, .valid_i, .instr_i, .src_a_i, .src_b_i, .pc_i,
        .load_data_i, .result_o, .wr_en_o, .flags_o, .br_taken_o, .br_target_o
    );

    typedef struct packed {
        logic [15:0] instr;
        logic [15:0] a;
        logic [15:0] b;
        logic [15:0] pc;
        logic [15:0] ld;
        logic [15:0] res;
        logic        wr;
        logic [2:0]  fl;
    } vec_t;

    localparam int NVEC = 21;
    localparam vec_t VECS [NVEC] = '{
        '{16'h1000, 16'h0003, 16'h0004, 16'h0000, 16'h0000, 16'h0007, 1'b1, 3'b001}, // R2 reg add
        '{16'h1036, 16'h000A, 16'h0005, 16'h0000, 16'h0000, 16'h0000, 1'b1, 3'b010}, // R2 imm 0x16
        '{16'h1000, 16'h7FFF, 16'h0001, 16'h0000, 16'h0000, 16'h8000, 1'b1, 3'b100}, // R3
        '{16'h1000, 16'hFFFF, 16'h0002, 16'h0000, 16'h0000, 16'h0001, 1'b1, 3'b001}, // R3 wrap
        '{16'h5000, 16'hF0F0, 16'h0FF0, 16'h0000, 16'h0000, 16'h00F0, 1'b1, 3'b001}, // R2 reg and
        '{16'h503F, 16'h8421, 16'h0000, 16'h0000, 16'h0000, 16'h8421, 1'b1, 3'b100}, // R2 imm and
        '{16'h5020, 16'hFFFF, 16'hFFFF, 16'h0000, 16'h0000, 16'h0000, 1'b1, 3'b010}, // R2 imm 0
        '{16'h903F, 16'h00FF, 16'h0000, 16'h0000, 16'h0000, 16'hFF00, 1'b1, 3'b100}, // R4
        '{16'h3000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 1'b0, 3'b100}, // R7
        '{16'h7000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 1'b0, 3'b100},
        '{16'hB000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 1'b0, 3'b100},
        '{16'h4800, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 1'b0, 3'b100},
        '{16'hC000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 1'b0, 3'b100},
        '{16'hF025, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 1'b0, 3'b100},
        '{16'hD000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 1'b0, 3'b100},
        '{16'h8000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 1'b0, 3'b100},
        '{16'h2000, 16'h0000, 16'h0000, 16'h0000, 16'h1234, 16'h1234, 1'b1, 3'b001}, // R6 ld
        '{16'h6000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 1'b1, 3'b010}, // R6 ldr
        '{16'hA000, 16'h0000, 16'h0000, 16'h0000, 16'h8000, 16'h8000, 1'b1, 3'b100}, // R6 ldi
        '{16'hE005, 16'h0000, 16'h0000, 16'h3000, 16'h0000, 16'h3005, 1'b1, 3'b001}, // R6 lea
        '{16'hE1FF, 16'h0000, 16'h0000, 16'h3000, 16'h0000, 16'h2FFF, 1'b1, 3'b001}  // R6 lea neg
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic v, input logic [15:0] ins, input logic [15:0] a,
                         input logic [15:0] b, input logic [15:0] pc, input logic [15:0] ld);
        valid_i = v; instr_i = ins; src_a_i = a; src_b_i = b; pc_i = pc; load_data_i = ld;
        @(negedge clk);
        valid_i = 1'b0;
    endtask

    initial begin
        #4000000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 flags in reset", {13'd0, flags_o}, 16'h0002);
        chk("R1 wr_en in reset", {15'd0, wr_en_o}, 16'h0000);
        chk("R1 result in reset", result_o, 16'h0000);
        chk("R1 br_taken in reset", {15'd0, br_taken_o}, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 flags after release", {13'd0, flags_o}, 16'h0002);

        // R9: mask 111 after reset is taken; target pc + 0x10
        issue(1'b1, 16'h0E10, 16'h0, 16'h0, 16'h3000, 16'h0);
        chk("R9 all-mask taken", {15'd0, br_taken_o}, 16'h0001);
        chk("R8 target", br_target_o, 16'h3010);
        // R9: empty mask never taken
        issue(1'b1, 16'h0010, 16'h0, 16'h0, 16'h3000, 16'h0);
        chk("R9 empty mask", {15'd0, br_taken_o}, 16'h0000);
        chk("R7 branch keeps flags", {13'd0, flags_o}, 16'h0002);

        for (int k = 0; k < NVEC; k++) begin
            issue(1'b1, VECS[k].instr, VECS[k].a, VECS[k].b, VECS[k].pc, VECS[k].ld);
            chk($sformatf("R6/R7 wr_en vec %0d", k), {15'd0, wr_en_o}, {15'd0, VECS[k].wr});
            chk($sformatf("R5 flags vec %0d", k), {13'd0, flags_o}, {13'd0, VECS[k].fl});
            chk($sformatf("R10 no branch vec %0d", k), {15'd0, br_taken_o}, 16'h0000);
            if (VECS[k].wr)
                chk($sformatf("R2/R3/R4/R6 result vec %0d", k), result_o, VECS[k].res);
        end

        // flags now P (001)
        issue(1'b1, 16'h09F0, 16'h0, 16'h0, 16'h3100, 16'h0);
        chk("R8 N mask vs P not taken", {15'd0, br_taken_o}, 16'h0000);
        issue(1'b1, 16'h05F0, 16'h0, 16'h0, 16'h3100, 16'h0);
        chk("R8 Z mask vs P not taken", {15'd0, br_taken_o}, 16'h0000);
        issue(1'b1, 16'h03F0, 16'h0, 16'h0, 16'h3100, 16'h0);
        chk("R8 P mask taken", {15'd0, br_taken_o}, 16'h0001);
        chk("R8 negative offset target", br_target_o, 16'h30F0);

        // R10: idle cycle with a tempting NOT on the bus
        issue(1'b0, 16'h903F, 16'h0000, 16'h0, 16'h0, 16'h0);
        chk("R10 idle wr_en", {15'd0, wr_en_o}, 16'h0000);
        chk("R10 idle br_taken", {15'd0, br_taken_o}, 16'h0000);
        chk("R10 idle flags hold", {13'd0, flags_o}, 16'h0001);

        // R3: 0x8000 + 0x8000 wraps to zero
        issue(1'b1, 16'h1000, 16'h8000, 16'h8000, 16'h0, 16'h0);
        chk("R3 wrap to zero", result_o, 16'h0000);
        chk("R5 zero flag", {13'd0, flags_o}, 16'h0002);
        // R2: immediate ignores src_b (imm 0x0F, b large)
        issue(1'b1, 16'h102F, 16'h0001, 16'h7000, 16'h0, 16'h0);
        chk("R2 imm ignores src_b", result_o, 16'h0010);
        chk("R5 positive flag", {13'd0, flags_o}, 16'h0001);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule